// File: doc/BRIEF.md
# Packet Transmit Framer

This block wraps a payload that the host has already placed in a transmit buffer with a fixed physical-layer frame and streams the result out one byte at a time. The host writes the buffer, then pulses a start strobe together with the payload length. The framer then sends the following bytes in order: a run of zero-valued preamble bytes, a start-of-frame delimiter, a length byte, the payload read from the buffer, and a 16-bit check sequence. It computes the check sequence while the payload passes through, so the payload is read from the buffer only once.

The output is a valid/ready byte stream. The buffer read port is asynchronous: the framer drives an address and a read strobe, and the buffer must return the byte in the same cycle. After the last check byte has been transferred, a one-cycle completion pulse tells the host that the whole packet has gone out. A start request that carries an illegal length is refused with a one-cycle error pulse, and no bytes are sent for it.

Top module: `pkt_tx_framer`

## Requirements
- R1: After reset, `out_valid_o`, `buf_rd_o`, `done_o` and `err_o` are all 0.
- R2: Each frame starts with 4 preamble bytes of value 0x00.
- R3: The byte that follows the preamble is the delimiter 0xA7.
- R4: The third field is one byte whose value is the payload length plus 2, so the count includes the check bytes.
- R5: Payload bytes are sent in the order of buffer addresses 0 to length-1. While a payload byte is presented, `buf_rd_o` is 1 and `buf_addr_o` holds that byte's address.
- R6: Two check bytes follow the payload, low byte first. They hold a CRC-16 with polynomial x^16+x^12+x^5+1 (reflected constant 0x8408), initial value 0, bits processed LSB first, and computed over the payload bytes only.
- R7: A byte advances only when `out_valid_o` and `out_ready_i` are both 1. While `out_ready_i` is 0, `out_valid_o` stays 1 and `out_data_o` does not change.
- R8: `done_o` is 1 for exactly one cycle, in the cycle right after the transfer of the second check byte, and at no other time.
- R9: A start request with a length of 0 or a length above 125 makes `err_o` 1 for one cycle in the next cycle, and no byte is sent.
- R10: A start request that arrives while a frame is in progress is ignored. The current frame continues unchanged, `err_o` stays 0, and no second frame follows.
- R11: Payload lengths of 1 and 125 are accepted and framed correctly.
- R12: While no frame is in progress, `out_valid_o` and `buf_rd_o` are 0. A frame begins only after a start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transmit request strobe |
| len_i | input | 8 | Payload length in bytes, sampled with the strobe |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_addr_o | output | 7 | Buffer read address |
| buf_data_i | input | 8 | Buffer byte, returned in the same cycle as the address |
| out_valid_o | output | 1 | Output byte is valid |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_data_o | output | 8 | Output byte |
| done_o | output | 1 | One-cycle pulse when the frame has been sent |
| err_o | output | 1 | One-cycle pulse when a start request is refused |

## Verification
The stall-hold property assumes that the buffer contents do not change between the start strobe and the completion pulse. A payload byte under back-pressure can only stay stable if the buffer it comes from is stable. The stimulus therefore loads the buffer before each start request and changes it only after `done_o` has been seen. The stimulus sends start requests during a frame only to check that they are ignored. Back-pressure comes from a pseudo-random ready pattern that changes away from the sampling edge, so every stall the checker sees is well-defined.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_PRE    = 3'd1,
      PH_SFD    = 3'd2,
      PH_LEN    = 3'd3,
      PH_PAY    = 3'd4,
      PH_FCS_LO = 3'd5,
      PH_FCS_HI = 3'd6
   } phase_e;

   localparam int unsigned CRC_W = 16;
endpackage

// File: rtl/ptf_len_gate.sv
module ptf_len_gate #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned MAX_PAYLOAD = 125
) (
   input  logic [DATA_W-1:0] len_i,
   output logic              len_ok_o
);
   localparam logic [DATA_W-1:0] MAX_V = DATA_W'(MAX_PAYLOAD);

   always_comb begin
      len_ok_o = (len_i != '0) && (len_i <= MAX_V);
   end
endmodule

// File: rtl/ptf_crc16.sv
module ptf_crc16
   import pkt_tx_pkg::*;
#(
   parameter int unsigned  DATA_W   = 8,
   parameter logic [15:0]  POLY_REV = 16'h8408,
   parameter logic [15:0]  INIT     = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] stage [0:DATA_W];

   assign stage[0] = crc_q ^ CRC_W'(data_i);

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY_REV)
                                      : (stage[g] >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= INIT;
      end else if (clr_i) begin
         crc_q <= INIT;
      end else if (en_i) begin
         crc_q <= stage[DATA_W];
      end
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/ptf_seq.sv
module ptf_seq
   import pkt_tx_pkg::*;
#(
   parameter int unsigned PRE_LEN = 4,
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned CNT_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] len_i,
   input  logic              len_ok_i,
   input  logic              fire_i,
   output phase_e            ph_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [ADDR_W-1:0] len_q_o,
   output logic              crc_clr_o,
   output logic              crc_en_o,
   output logic              done_o,
   output logic              err_o
);
   localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN - 1);

   phase_e            ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] len_q;
   logic              done_q, err_q;
   logic              accept;
   logic              pay_last;

   assign accept   = (ph_q == PH_IDLE) && start_i && len_ok_i;
   assign pay_last = (cnt_q == (CNT_W'(len_q) - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         len_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (start_i) begin
                  if (len_ok_i) begin
                     ph_q  <= PH_PRE;
                     cnt_q <= '0;
                     len_q <= len_i;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            PH_PRE: begin
               if (fire_i) begin
                  if (cnt_q == PRE_LAST) begin
                     ph_q  <= PH_SFD;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            PH_SFD: begin
               if (fire_i) ph_q <= PH_LEN;
            end
            PH_LEN: begin
               if (fire_i) begin
                  ph_q  <= PH_PAY;
                  cnt_q <= '0;
               end
            end
            PH_PAY: begin
               if (fire_i) begin
                  if (pay_last) begin
                     ph_q  <= PH_FCS_LO;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            PH_FCS_LO: begin
               if (fire_i) ph_q <= PH_FCS_HI;
            end
            PH_FCS_HI: begin
               if (fire_i) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign ph_o      = ph_q;
   assign cnt_o     = cnt_q;
   assign len_q_o   = len_q;
   assign crc_clr_o = accept;
   assign crc_en_o  = (ph_q == PH_PAY) && fire_i;
   assign done_o    = done_q;
   assign err_o     = err_q;
endmodule

// File: rtl/ptf_byte_mux.sv
module ptf_byte_mux
   import pkt_tx_pkg::*;
#(
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       ADDR_W   = 7,
   parameter logic [DATA_W-1:0] PRE_BYTE = 8'h00,
   parameter logic [DATA_W-1:0] SFD_BYTE = 8'hA7
) (
   input  phase_e            ph_i,
   input  logic [ADDR_W-1:0] len_q_i,
   input  logic [DATA_W-1:0] pay_i,
   input  logic [CRC_W-1:0]  crc_i,
   output logic [DATA_W-1:0] byte_o
);
   logic [DATA_W-1:0] len_byte;

   assign len_byte = DATA_W'(len_q_i) + DATA_W'(2);

   always_comb begin
      unique case (ph_i)
         PH_PRE:    byte_o = PRE_BYTE;
         PH_SFD:    byte_o = SFD_BYTE;
         PH_LEN:    byte_o = len_byte;
         PH_PAY:    byte_o = pay_i;
         PH_FCS_LO: byte_o = crc_i[7:0];
         PH_FCS_HI: byte_o = crc_i[15:8];
         default:   byte_o = '0;
      endcase
   end
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
   import pkt_tx_pkg::*;
#(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       MAX_PAYLOAD = 125,
   parameter int unsigned       PRE_LEN     = 4,
   parameter logic [DATA_W-1:0] PRE_BYTE    = 8'h00,
   parameter logic [DATA_W-1:0] SFD_BYTE    = 8'hA7,
   parameter logic [15:0]       CRC_POLY    = 16'h8408,
   parameter logic [15:0]       CRC_INIT    = 16'h0000,
   localparam int unsigned      ADDR_W      = $clog2(MAX_PAYLOAD),
   localparam int unsigned      PRE_W       = $clog2(PRE_LEN + 1),
   localparam int unsigned      CNT_W       = (ADDR_W > PRE_W) ? ADDR_W : PRE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] len_i,
   output logic              buf_rd_o,
   output logic [ADDR_W-1:0] buf_addr_o,
   input  logic [DATA_W-1:0] buf_data_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [DATA_W-1:0] out_data_o,
   output logic              done_o,
   output logic              err_o
);
   if (DATA_W != 8) begin : g_bad_width
      $error("pkt_tx_framer: byte stream must be 8 bits wide");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("pkt_tx_framer: at least one preamble byte is needed");
   end
   if (MAX_PAYLOAD < 1 || MAX_PAYLOAD + 2 > 255) begin : g_bad_max
      $error("pkt_tx_framer: payload limit must leave room in the length byte");
   end

   phase_e            ph;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] len_q;
   logic              len_ok;
   logic              fire;
   logic              crc_clr, crc_en;
   logic [CRC_W-1:0]  crc;

   assign out_valid_o = (ph != PH_IDLE);
   assign fire        = out_valid_o && out_ready_i;
   assign buf_rd_o    = (ph == PH_PAY);
   assign buf_addr_o  = buf_rd_o ? cnt[ADDR_W-1:0] : '0;

   ptf_len_gate #(
      .DATA_W      (DATA_W),
      .MAX_PAYLOAD (MAX_PAYLOAD)
   ) u_gate (
      .len_i    (len_i),
      .len_ok_o (len_ok)
   );

   ptf_seq #(
      .PRE_LEN (PRE_LEN),
      .ADDR_W  (ADDR_W),
      .CNT_W   (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .len_i     (len_i[ADDR_W-1:0]),
      .len_ok_i  (len_ok),
      .fire_i    (fire),
      .ph_o      (ph),
      .cnt_o     (cnt),
      .len_q_o   (len_q),
      .crc_clr_o (crc_clr),
      .crc_en_o  (crc_en),
      .done_o    (done_o),
      .err_o     (err_o)
   );

   ptf_crc16 #(
      .DATA_W   (DATA_W),
      .POLY_REV (CRC_POLY),
      .INIT     (CRC_INIT)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (crc_clr),
      .en_i   (crc_en),
      .data_i (buf_data_i),
      .crc_o  (crc)
   );

   ptf_byte_mux #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .PRE_BYTE (PRE_BYTE),
      .SFD_BYTE (SFD_BYTE)
   ) u_mux (
      .ph_i    (ph),
      .len_q_i (len_q),
      .pay_i   (buf_data_i),
      .crc_i   (crc),
      .byte_o  (out_data_o)
   );
endmodule

// File: rtl/ptf_chk.sv
module ptf_chk
   import pkt_tx_pkg::*;
#(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       ADDR_W      = 7,
   parameter int unsigned       MAX_PAYLOAD = 125,
   parameter logic [DATA_W-1:0] SFD_BYTE    = 8'hA7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              buf_rd_o,
   input logic [ADDR_W-1:0] buf_addr_o,
   input logic              out_valid_o,
   input logic              out_ready_i,
   input logic [DATA_W-1:0] out_data_o,
   input logic              done_o,
   input logic              err_o,
   input phase_e            ph,
   input logic [ADDR_W-1:0] len_q
);
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_after_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(out_valid_o && out_ready_i));

   p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !out_valid_o);

   p_busy_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && start_i) |=> !err_o);

   p_sfd_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_SFD) |-> (out_data_o == SFD_BYTE));

   p_addr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd_o |-> ((buf_addr_o < len_q) && out_valid_o));

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |-> (!out_valid_o && !buf_rd_o));

   p_len_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE) |-> ((len_q != '0) && (len_q <= ADDR_W'(MAX_PAYLOAD))));
endmodule

bind pkt_tx_framer ptf_chk #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .MAX_PAYLOAD (MAX_PAYLOAD),
   .SFD_BYTE    (SFD_BYTE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .buf_rd_o    (buf_rd_o),
   .buf_addr_o  (buf_addr_o),
   .out_valid_o (out_valid_o),
   .out_ready_i (out_ready_i),
   .out_data_o  (out_data_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .ph          (ph),
   .len_q       (len_q)
);

// File: tb/pkt_tx_framer_tb.sv
module pkt_tx_framer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] len_i = '0;
   logic       buf_rd_o;
   logic [6:0] buf_addr_o;
   logic [7:0] buf_data_i;
   logic       out_valid_o;
   logic       out_ready_i = 1'b1;
   logic [7:0] out_data_o;
   logic       done_o;
   logic       err_o;

   logic [7:0] mem [0:127];
   assign buf_data_i = mem[buf_addr_o];

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_b [$];
   string      exp_r [$];
   bit         expect_done = 0;
   bit         prev_stall  = 0;
   logic [7:0] prev_data   = '0;
   bit         rand_ready  = 0;
   logic [15:0] lfsr = 16'hACE1;
   int          cycles = 0;
   bit          finished = 0;

   always #2 clk = ~clk;

   pkt_tx_framer u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .buf_rd_o(buf_rd_o), .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
      .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
      .done_o(done_o), .err_o(err_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // ready pattern changes away from the sampling (falling) edge
   always @(posedge clk) begin
      #1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready_i <= rand_ready ? (lfsr[0] | lfsr[5]) : 1'b1;
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (expect_done) begin
            check(done_o == 1'b1, "R8 done pulse", done_o, 1);
            expect_done = 0;
         end else if (done_o) begin
            check(0, "R8 unexpected done", 1, 0);
         end
         if (prev_stall) begin
            check(out_valid_o && out_data_o == prev_data, "R7 stall hold", out_data_o, prev_data);
         end
         if (out_valid_o && out_ready_i) begin
            if (exp_b.size() == 0) begin
               check(0, "R12 unexpected byte", out_data_o, 0);
            end else begin
               logic [7:0] eb;
               string      er;
               eb = exp_b.pop_front();
               er = exp_r.pop_front();
               check(out_data_o == eb, er, out_data_o, eb);
               if (er == "R5 payload") check(buf_rd_o == 1'b1, "R5 read strobe", buf_rd_o, 1);
               if (exp_b.size() == 0) expect_done = 1;
            end
         end
         prev_stall = out_valid_o && !out_ready_i;
         prev_data  = out_data_o;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(0, "watchdog", cycles, 0);
         report();
      end
   end

   function automatic logic [15:0] crc_ref(input int n);
      logic [15:0] c = 16'h0000;
      for (int i = 0; i < n; i++) begin
         c = c ^ {8'h00, mem[i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      end
      return c;
   endfunction

   task automatic pulse_start(input logic [7:0] l);
      @(posedge clk); #1;
      start_i = 1'b1; len_i = l;
      @(posedge clk); #1;
      start_i = 1'b0;
   endtask

   // driver: pushes the expected frame, then requests it
   task automatic queue_frame(input int n, input bit known_fcs);
      logic [15:0] c;
      for (int i = 0; i < 4; i++) begin exp_b.push_back(8'h00); exp_r.push_back("R2 preamble"); end
      exp_b.push_back(8'hA7); exp_r.push_back("R3 delimiter");
      exp_b.push_back(8'(n + 2)); exp_r.push_back("R4 length");
      for (int i = 0; i < n; i++) begin exp_b.push_back(mem[i]); exp_r.push_back("R5 payload"); end
      c = known_fcs ? 16'h2189 : crc_ref(n);
      exp_b.push_back(c[7:0]);  exp_r.push_back("R6 fcs low");
      exp_b.push_back(c[15:8]); exp_r.push_back("R6 fcs high");
      pulse_start(8'(n));
   endtask

   task automatic wait_done();
      int k = 0;
      while (!done_o && k < 2000) begin @(negedge clk); k++; end
      @(negedge clk);
      check(exp_b.size() == 0, "R8 frame complete", exp_b.size(), 0);
   endtask

   task automatic fill(input int n, input int seed);
      for (int i = 0; i < n; i++) mem[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2));
   endtask

   task automatic reject(input logic [7:0] l);
      pulse_start(l);
      @(negedge clk);
      check(err_o == 1'b1, "R9 error pulse", err_o, 1);
      @(negedge clk);
      check(err_o == 1'b0, "R9 error single", err_o, 0);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(!out_valid_o, "R9 nothing sent", out_valid_o, 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid_o && !buf_rd_o && !done_o && !err_o, "R1 reset state",
            {out_valid_o, buf_rd_o, done_o, err_o}, 0);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(!out_valid_o && !buf_rd_o, "R12 idle quiet", out_valid_o, 0);
      end

      // known vector "123456789"
      for (int i = 0; i < 9; i++) mem[i] = 8'h31 + 8'(i);
      queue_frame(9, 1);
      wait_done();

      // shortest payload, back-pressure
      rand_ready = 1;
      mem[0] = 8'h5C;
      queue_frame(1, 0);
      wait_done();
      check(1, "R11 length 1", 1, 1);

      // longest payload, back-pressure
      fill(125, 3);
      queue_frame(125, 0);
      wait_done();
      check(1, "R11 length 125", 1, 1);

      // illegal lengths
      reject(8'd0);
      reject(8'd126);
      reject(8'd200);

      // start requests during a frame are ignored
      fill(20, 7);
      queue_frame(20, 0);
      repeat (8) @(posedge clk);
      #1 start_i = 1'b1; len_i = 8'd5;
      @(posedge clk); #1 len_i = 8'd0;
      @(posedge clk); #1 start_i = 1'b0;
      @(negedge clk);
      check(!err_o, "R10 no error while busy", err_o, 0);
      wait_done();
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check(!out_valid_o, "R10 no second frame", out_valid_o, 0);
      end

      // back-to-back frames, start right after done
      rand_ready = 0;
      fill(7, 9);
      queue_frame(7, 0);
      wait_done();
      fill(3, 2);
      queue_frame(3, 0);
      wait_done();

      repeat (4) @(negedge clk);
      report();
   end
endmodule